// File: doc/BRIEF.md
# Serial SAR converter control sequencer

This block is the digital sequencer of an 8-bit successive-approximation converter that a host controls over a three-wire serial link. The host lowers an active-low chip-select, clocks a start bit and a four-bit channel-assignment word in on a data-in pin, and receives the result on a data-out pin. Data-out is driven only when its enable output is high, forming a tri-state pair. The block decodes the assignment word into one-hot positive and negative input selects for an external 8-channel analog switch. It runs the binary-search trial register that feeds an external resistor ladder, and it reads a one-bit comparator result once per clock.

Conversion and serial output overlap. Each trial bit goes out on data-out in the falling clock edge right after the rising edge that decides it, MSB first. A status output is high while the search runs. After the last bit, a 9-bit shift register either holds the final LSB on the line or replays the byte LSB first, under the control of a hold input. Data-in is looked at only before conversion starts and data-out is idle at that time, so the two pins may share one wire. Raising chip-select clears every register at once.

The control state machine has five states. IDLE waits for a 1 on data-in (the start transition). ADDR takes in the word bits; on the fourth bit it latches the channel and moves to SETTLE. SETTLE is the one-period settling gap; it decides the MSB and moves to CONV. CONV decides the remaining bits and moves to REPLAY on the LSB. REPLAY stays until chip-select rises. A rising chip-select returns any state to IDLE.

Top module: `sar_serial_seq`

## Requirements
- R1: While cs_n is high, dout_oe, dout, sars, trial, pos_sel, neg_sel and neg_com are all 0, whatever the clock does.
- R2: With cs_n low, rising edges that sample din = 0 before the start bit change nothing (dout_oe and sars stay 0). The first sampled 1 is the start bit.
- R3: The four rising edges after the start bit sample the word bits in the order single-ended flag, odd flag, pair bit 1, pair bit 0. The edge that samples the last word bit raises sars and latches the selects.
- R4: On the falling edge right after that edge, dout_oe goes to 1 and dout drives 0 for one clock period.
- R5: On the next eight falling edges dout carries result bits 7 down to 0. sars falls at the rising edge that decides bit 0, so sars is high while bits 7..1 are shown and low when bit 0 is shown.
- R6: Each trial sets one bit of trial, MSB first. That bit is kept if cmp is 1 at the next rising edge and cleared if it is 0, so the result is the largest value v with every kept step satisfying cmp. A comparator that reports 0 on every trial gives the result 0.
- R7: In the replay phase, a rising edge that samples lsb_hold = 1 leaves dout unchanged, so dout keeps showing bit 0.
- R8: Each rising edge in the replay phase that samples lsb_hold = 0 shifts the stored byte. On the following falling edge dout shows the next higher bit (1, 2, … 7) and then 0 from then on.
- R9: Single-ended code (single flag = 1): channel number = 4·pair1 + 2·pair0 + odd. pos_sel is that channel one-hot, neg_sel = 0, and neg_com = 1 (ground or common is the negative side).
- R10: Differential code (single flag = 0): pos_sel selects channel 4·pair1 + 2·pair0 + odd and neg_sel selects the other channel of the same pair, 4·pair1 + 2·pair0 + (1 − odd). neg_com = 0.
- R11: After the selects latch, din has no effect on the selects, the result, the replay or the state sequence until cs_n rises.
- R12: pos_sel, neg_sel and neg_com hold their latched value until cs_n rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip-select; high clears the block asynchronously |
| din | input | 1 | Serial address data, sampled on rising edges |
| lsb_hold | input | 1 | High: keep the final LSB on dout; low: replay the result LSB first |
| cmp | input | 1 | Comparator result: 1 when the selected input is at or above trial |
| dout | output | 1 | Serial result data, updated on falling edges |
| dout_oe | output | 1 | Drive enable for dout (0 = high impedance) |
| sars | output | 1 | High while the successive-approximation search runs |
| trial | output | 8 | Trial value sent to the ladder |
| pos_sel | output | 8 | One-hot select of the positive input channel |
| neg_sel | output | 8 | One-hot select of the negative input channel (0 when the negative side is ground or common) |
| neg_com | output | 1 | 1 when the negative side is ground or the common input |

## Verification
The rising edge that samples the last word bit is the reference point. sars and the selects are due right after it. The settling 0 on dout, with dout_oe high, is due on the falling edge after it. Result bit 7 comes one falling edge later, and bit 0 eight falling edges after the settling 0, with sars already low. Replay bits come one falling edge after each rising edge that samples lsb_hold low. The bench drives inputs and reads outputs one nanosecond after every falling edge, so each read sees exactly the state after the previous rising edge and the output stage after the falling edge just passed. The deselect checks are made one nanosecond after cs_n rises, with no clock edge in between.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_SETTLE,
        S_CONV,
        S_REPLAY
    } seq_st_t;

endpackage

// File: rtl/sar_chan_decode.sv
module sar_chan_decode #(
    parameter int N_CH = 8,
    localparam int CW = $clog2(N_CH)
) (
    input  logic            clk,
    input  logic            clr,
    input  logic            latch,
    input  logic [CW:0]     word,
    output logic [N_CH-1:0] pos_sel,
    output logic [N_CH-1:0] neg_sel,
    output logic            neg_com
);

    localparam logic [N_CH-1:0] ONE = {{(N_CH-1){1'b0}}, 1'b1};

    logic [CW-1:0] pch;
    logic [CW-1:0] nch;

    // word = {single flag, odd flag, pair index}
    assign pch = {word[CW-2:0], word[CW-1]};
    assign nch = {word[CW-2:0], ~word[CW-1]};

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            pos_sel <= '0;
            neg_sel <= '0;
            neg_com <= 1'b0;
        end else if (latch) begin
            pos_sel <= ONE << pch;
            if (word[CW]) begin
                neg_sel <= '0;
                neg_com <= 1'b1;
            end else begin
                neg_sel <= ONE << nch;
                neg_com <= 1'b0;
            end
        end
    end

    // R10
    neg_side_chk: assert property (@(posedge clk) disable iff (clr)
        (pos_sel != '0) |-> ((pos_sel & neg_sel) == '0 &&
            (neg_com ? (neg_sel == '0) : ($countones(neg_sel) == 1))));

endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
    parameter int W = 8,
    localparam int BW = $clog2(W)
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          load,
    input  logic          decide,
    input  logic [BW-1:0] bitpos,
    input  logic          cmp,
    output logic [W-1:0]  trial
);

    localparam logic [W-1:0] TOP = {1'b1, {(W-1){1'b0}}};

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            trial <= '0;
        end else if (load) begin
            trial <= TOP;
        end else if (decide) begin
            trial[bitpos] <= cmp;
            if (bitpos != '0) begin
                trial[bitpos - BW'(1)] <= 1'b1;
            end
        end
    end

    // R6
    msb_kept_chk: assert property (@(posedge clk) disable iff (clr)
        (decide && bitpos != BW'(W-1)) |=> $stable(trial[W-1]));

endmodule

// File: rtl/sar_out_stage.sv
module sar_out_stage #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic clr,
    input  logic capture,
    input  logic replay_shift,
    input  logic drive,
    input  logic bit_in,
    output logic dout,
    output logic dout_oe
);

    // 9-bit store: decided bits shift in at the bottom, replay shifts down
    logic [W:0] sreg;

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            sreg <= '0;
        end else if (capture) begin
            sreg <= {sreg[W-1:0], bit_in};
        end else if (replay_shift) begin
            sreg <= {1'b0, sreg[W:1]};
        end
    end

    always_ff @(negedge clk or posedge clr) begin
        if (clr) begin
            dout    <= 1'b0;
            dout_oe <= 1'b0;
        end else begin
            dout    <= sreg[0];
            dout_oe <= drive;
        end
    end

    // R4
    oe_follow_chk: assert property (@(posedge clk) disable iff (clr)
        dout_oe == drive);

endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
    import sar_seq_pkg::*;
#(
    parameter int RES_BITS = 8,
    parameter int N_CH     = 8
) (
    input  logic                clk,
    input  logic                cs_n,
    input  logic                din,
    input  logic                lsb_hold,
    input  logic                cmp,
    output logic                dout,
    output logic                dout_oe,
    output logic                sars,
    output logic [RES_BITS-1:0] trial,
    output logic [N_CH-1:0]     pos_sel,
    output logic [N_CH-1:0]     neg_sel,
    output logic                neg_com
);

    localparam int CW     = $clog2(N_CH);
    localparam int WORD_N = CW + 1;
    localparam int CNT_W  = $clog2(WORD_N + 1);
    localparam int BW     = $clog2(RES_BITS);

    seq_st_t          st;
    seq_st_t          st_nx;
    logic [CNT_W-1:0] cnt;
    logic [BW-1:0]    bitpos;
    logic [CW:0]      word;
    logic             latch;
    logic             decide;
    logic             replay_shift;
    logic             drive;
    logic             last_word_bit;

    assign last_word_bit = (cnt == CNT_W'(WORD_N - 1));

    // state register and sequencing counters
    always_ff @(posedge clk or posedge cs_n) begin
        if (cs_n) begin
            st     <= S_IDLE;
            cnt    <= '0;
            bitpos <= '0;
            word   <= '0;
        end else begin
            st <= st_nx;
            if (st == S_ADDR) begin
                word <= {word[CW-1:0], din};
                cnt  <= cnt + CNT_W'(1);
            end
            if (latch) begin
                bitpos <= BW'(RES_BITS - 1);
            end else if (decide && bitpos != '0) begin
                bitpos <= bitpos - BW'(1);
            end
        end
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:   if (din) st_nx = S_ADDR;
            S_ADDR:   if (last_word_bit) st_nx = S_SETTLE;
            S_SETTLE: st_nx = S_CONV;
            S_CONV:   if (bitpos == '0) st_nx = S_REPLAY;
            S_REPLAY: st_nx = S_REPLAY;
            default:  st_nx = S_IDLE;
        endcase
    end

    // state decodes
    always_comb begin
        latch        = 1'b0;
        decide       = 1'b0;
        replay_shift = 1'b0;
        drive        = 1'b0;
        sars         = 1'b0;
        unique case (st)
            S_IDLE:   ;
            S_ADDR:   latch = last_word_bit;
            S_SETTLE, S_CONV: begin
                decide = 1'b1;
                drive  = 1'b1;
                sars   = 1'b1;
            end
            S_REPLAY: begin
                drive        = 1'b1;
                replay_shift = ~lsb_hold;
            end
            default:  ;
        endcase
    end

    sar_chan_decode #(.N_CH(N_CH)) u_dec (
        .clk     (clk),
        .clr     (cs_n),
        .latch   (latch),
        .word    ({word[CW-1:0], din}),
        .pos_sel (pos_sel),
        .neg_sel (neg_sel),
        .neg_com (neg_com)
    );

    sar_trial #(.W(RES_BITS)) u_trial (
        .clk    (clk),
        .clr    (cs_n),
        .load   (latch),
        .decide (decide),
        .bitpos (bitpos),
        .cmp    (cmp),
        .trial  (trial)
    );

    sar_out_stage #(.W(RES_BITS)) u_out (
        .clk          (clk),
        .clr          (cs_n),
        .capture      (decide),
        .replay_shift (replay_shift),
        .drive        (drive),
        .bit_in       (cmp),
        .dout         (dout),
        .dout_oe      (dout_oe)
    );

    // R4
    sars_drive_chk: assert property (@(posedge clk) disable iff (cs_n)
        sars |-> dout_oe);

    // R9
    pos_onehot_chk: assert property (@(posedge clk) disable iff (cs_n)
        sars |-> ($countones(pos_sel) == 1));

    // R12
    sel_stable_chk: assert property (@(posedge clk) disable iff (cs_n)
        (st == S_CONV || st == S_REPLAY) |=>
            ($stable(pos_sel) && $stable(neg_sel) && $stable(neg_com)));

    // R7
    lsb_hold_chk: assert property (@(posedge clk) disable iff (cs_n)
        (st == S_REPLAY && lsb_hold) |=> $stable(dout));

endmodule

// File: tb/sim_sar_serial_seq.sv
module sim_sar_serial_seq;

    logic       clk = 1'b0;
    logic       cs_n = 1'b1;
    logic       din = 1'b0;
    logic       lsb_hold = 1'b0;
    logic       cmp;
    logic       dout;
    logic       dout_oe;
    logic       sars;
    logic [7:0] trial;
    logic [7:0] pos_sel;
    logic [7:0] neg_sel;
    logic       neg_com;

    logic [7:0] chv [8];
    int         comv = 0;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    sar_serial_seq u0 (
        .clk(clk), .cs_n(cs_n), .din(din), .lsb_hold(lsb_hold), .cmp(cmp),
        .dout(dout), .dout_oe(dout_oe), .sars(sars), .trial(trial),
        .pos_sel(pos_sel), .neg_sel(neg_sel), .neg_com(neg_com)
    );

    // behavioural analog switch and comparator
    always_comb begin
        int pv;
        int nv;
        pv = 0;
        nv = 0;
        for (int i = 0; i < 8; i++) begin
            if (pos_sel[i]) pv = int'(chv[i]);
            if (neg_sel[i]) nv = int'(chv[i]);
        end
        if (neg_com) nv = comv;
        cmp = ((pv - nv) >= int'(trial));
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_clear(input string req);
        int act;
        act = int'(dout_oe) + int'(dout) + int'(sars) + int'(trial) +
              int'(pos_sel) + int'(neg_sel) + int'(neg_com);
        chk(act == 0, req, act, 0);
    endtask

    task automatic run_conv(input logic [3:0] w, input int lead, input int hold, input bit tog);
        int pi;
        int ni;
        int expv;
        logic [7:0] ep;
        logic [7:0] en;
        logic       ec;
        logic [7:0] got;
        logic [8:0] rep;
        logic [8:0] rexp;
        bit ok;
        pi = int'(w[1:0]) * 2 + int'(w[2]);
        ni = int'(w[1:0]) * 2 + int'(!w[2]);
        ep = 8'd1 << pi;
        if (w[3]) begin
            en = 8'd0; ec = 1'b1; expv = int'(chv[pi]) - comv;
        end else begin
            en = 8'd1 << ni; ec = 1'b0; expv = int'(chv[pi]) - int'(chv[ni]);
        end
        if (expv < 0) expv = 0;
        if (expv > 255) expv = 255;

        lsb_hold = (hold > 0);
        cs_n = 1'b0;
        din  = 1'b0;
        repeat (lead) step();
        chk(!dout_oe && !sars, "R2 idle before start", int'(dout_oe) + int'(sars), 0);
        din = 1'b1; step();
        din = w[3]; step();
        din = w[2]; step();
        din = w[1]; step();
        din = w[0];
        chk(!sars && !dout_oe, "R3 no early start", int'(sars) + int'(dout_oe), 0);
        step();
        chk(sars == 1'b1, "R3 sars on last word bit", int'(sars), 1);
        chk(dout_oe && !dout, "R4 settling zero", {dout_oe, dout}, 2);
        if (w[3])
            chk(pos_sel == ep && neg_sel == en && neg_com == ec, "R9 single decode",
                {pos_sel, neg_sel, neg_com}, {ep, en, ec});
        else
            chk(pos_sel == ep && neg_sel == en && neg_com == ec, "R10 diff decode",
                {pos_sel, neg_sel, neg_com}, {ep, en, ec});

        ok = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            if (tog) din = ~din;
            step();
            got[i] = dout;
            if (sars != (i != 0) || !dout_oe) ok = 1'b0;
        end
        chk(ok, "R5 sars and drive during stream", int'(ok), 1);
        chk(got == expv[7:0], "R6 R11 result", int'(got), expv);

        if (hold > 0) begin
            ok = 1'b1;
            for (int k = 0; k < hold; k++) begin
                if (tog) din = ~din;
                step();
                if (dout !== expv[0] || !dout_oe) ok = 1'b0;
            end
            chk(ok, "R7 hold keeps LSB", int'(dout), expv[0]);
        end
        lsb_hold = 1'b0;
        rexp = {1'b0, expv[7:0]};
        for (int k = 1; k <= 8; k++) begin
            if (tog) din = ~din;
            step();
            rep[k] = dout;
        end
        rep[0] = got[0];
        chk(rep == rexp, "R8 LSB-first replay", int'(rep), int'(rexp));
        chk(pos_sel == ep && neg_sel == en && neg_com == ec, "R11 R12 selects held",
            {pos_sel, neg_sel, neg_com}, {ep, en, ec});

        cs_n = 1'b1;
        din  = 1'b0;
        #1;
        chk_clear("R1 cleared on deselect");
        step();
        step();
    endtask

    initial begin
        for (int i = 0; i < 8; i++) chv[i] = 8'd0;
        step();
        chk_clear("R1 reset state");
        repeat (3) step();
        chk_clear("R1 clocked while deselected");

        for (int run = 0; run < 48; run++) begin
            for (int i = 0; i < 8; i++) chv[i] = 8'((i * 47 + run * 31 + 13) % 256);
            comv = (run / 16 == 2) ? 40 : 0;
            run_conv(4'(run % 16), run % 3, run % 4, run[0]);
        end

        // boundary values
        for (int i = 0; i < 8; i++) chv[i] = 8'd255;
        comv = 0;
        run_conv(4'b1000, 1, 2, 1'b1);
        run_conv(4'b0101, 0, 0, 1'b0);
        chv[3] = 8'd0;
        run_conv(4'b0001, 2, 1, 1'b1);
        run_conv(4'b1011, 0, 1, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule